// File: doc/BRIEF.md
# Five-Requester Move-to-Last Bus Arbiter

This block decides which of five bus masters owns a shared bus. Master 0 is the host controller inside the arbiter's own domain. Its request arrives on a separate internal input and is never placed on the external request pins. Masters 1 to 4 are external, and each has its own request and grant pair. A static mode input selects the policy. In fixed mode the lower index always wins. In rotating mode the arbiter keeps an ordered list of all five masters, and the master that has just finished using the bus is moved to the tail of that list.

A grant is registered. Once it is given, it stays unchanged until a transfer-complete pulse arrives, whatever the requests do in the meantime. The pulse clears the grant, and in rotating mode it also updates the list. A new decision is made on the cycle after the pulse.

Top module: `mtl_bus_arbiter`

## Requirements
- R1: The grant vector {gnt_ext[3:0], gnt_host}, with bit k for master k, is one-hot or all zero. A bit rises only for a master whose request was high in the cycle before.
- R2: With mode_rr=0, a decision grants the lowest-indexed requesting master (0 before 1 before 2 before 3 before 4).
- R3: After reset, the stored list in rotating mode is 0,1,2,3,4 from highest to lowest priority.
- R4: With mode_rr=1, a decision grants the requesting master that stands highest in the stored list.
- R5: In rotating mode, completion of a transfer moves the granted master to the tail of the list. The other masters keep their relative order. Example from reset: winner 1 gives 0,2,3,4,1, then winner 0 gives 2,3,4,1,0, then winner 3 gives 2,4,1,0,3.
- R6: The list changes only on a cycle where xfer_done completes a grant and mode_rr=1. Issuing a grant, or completing one in fixed mode, leaves the list as it was. In fixed mode the list is not used.
- R7: A grant is held unchanged while xfer_done is low. When xfer_done is high during a grant, the grant is zero in the next cycle. A pending request is granted again in the cycle after that.
- R8: In an idle cycle with a request present, the grant appears in the next cycle. With no request present, no grant is given and the list does not change.
- R9: The stored list is a permutation of 0 to 4 at all times.
- R10: Reset clears the grant and restores the list, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rr | input | 1 | 0 selects fixed priority, 1 selects move-to-last rotation |
| req_host | input | 1 | Request from the internal host controller (master 0) |
| req_ext | input | 4 | Requests from external masters 1 to 4 (bit i-1 is master i) |
| xfer_done | input | 1 | Pulse marking that the current owner's transfer has completed |
| gnt_host | output | 1 | Grant to the host controller |
| gnt_ext | output | 4 | Grants to external masters 1 to 4 |

## Verification
The main stimulus is a table of rounds. Each round sets a mode and a request mix, checks the resulting grant, and then completes the transfer. The rounds replay the three-step rotation example from reset and then continue into mixes where the list order and the index order give different winners, so a rotating arbiter and a fixed one are told apart. Fixed-mode rounds are placed between rotating rounds and are chosen so that an arbiter that wrongly updates the list in fixed mode would grant a different master afterwards. Directed tests cover an empty request vector, request changes during a held grant, regrant timing after completion, and reset in the middle of a transfer from a rotated list.

// File: rtl/mtl_arb_pkg.sv
package mtl_arb_pkg;
  localparam int NUM_MASTERS = 5;
  localparam int IDX_W = $clog2(NUM_MASTERS);
endpackage

// File: rtl/mtl_prio_list.sv
// Ordered list of master indices, slot 0 = highest priority.
module mtl_prio_list #(
  parameter int N  = mtl_arb_pkg::NUM_MASTERS,
  parameter int IW = mtl_arb_pkg::IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic [IW-1:0]        winner,
  output logic [N-1:0][IW-1:0] order
);
  logic [N-1:0][IW-1:0] order_q, order_d;
  logic [N-1:0]         at_or_after;

  // Mark every slot at or behind the winner's current position.
  always_comb begin
    at_or_after = '0;
    for (int i = 0; i < N; i++) begin
      if (i == 0) at_or_after[i] = (order_q[i] == winner);
      else        at_or_after[i] = at_or_after[i-1] | (order_q[i] == winner);
    end
  end

  generate
    for (genvar s = 0; s < N; s++) begin : g_slot
      if (s == N - 1) begin : g_tail
        assign order_d[s] = at_or_after[s] ? winner : order_q[s];
      end else begin : g_body
        assign order_d[s] = at_or_after[s] ? order_q[s+1] : order_q[s];
      end
      always_ff @(posedge clk) begin
        if (rst)      order_q[s] <= IW'(s);
        else if (upd) order_q[s] <= order_d[s];
      end
    end
  endgenerate

  assign order = order_q;
endmodule

// File: rtl/mtl_pick_winner.sv
// Combinational choice of the winning master for one decision.
module mtl_pick_winner #(
  parameter int N  = mtl_arb_pkg::NUM_MASTERS,
  parameter int IW = mtl_arb_pkg::IDX_W
) (
  input  logic [N-1:0]         req,
  input  logic                 mode_rr,
  input  logic [N-1:0][IW-1:0] order,
  output logic                 any_req,
  output logic [IW-1:0]        winner
);
  logic [IW-1:0] cand;

  always_comb begin
    winner = '0;
    cand   = '0;
    // Walk from lowest to highest priority so the highest one found last wins.
    for (int i = N - 1; i >= 0; i--) begin
      cand = mode_rr ? order[i] : IW'(i);
      if (req[cand]) winner = cand;
    end
  end

  assign any_req = |req;
endmodule

// File: rtl/mtl_grant_ctrl.sv
// Registers the grant and holds it until the transfer completes.
module mtl_grant_ctrl #(
  parameter int N  = mtl_arb_pkg::NUM_MASTERS,
  parameter int IW = mtl_arb_pkg::IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_req,
  input  logic [IW-1:0] pick,
  input  logic          done,
  input  logic          mode_rr,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] owner,
  output logic          list_upd
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_t;
  st_t           st_q;
  logic [N-1:0]  gnt_q;
  logic [IW-1:0] owner_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      gnt_q   <= '0;
      owner_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (any_req) begin
          st_q    <= ST_BUSY;
          gnt_q   <= N'(1) << pick;
          owner_q <= pick;
        end
        ST_BUSY: if (done) begin
          st_q  <= ST_IDLE;
          gnt_q <= '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign gnt      = gnt_q;
  assign owner    = owner_q;
  assign list_upd = (st_q == ST_BUSY) && done && mode_rr;
endmodule

// File: rtl/mtl_bus_arbiter.sv
module mtl_bus_arbiter #(
  parameter int N  = mtl_arb_pkg::NUM_MASTERS,
  parameter int IW = mtl_arb_pkg::IDX_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_rr,
  input  logic         req_host,
  input  logic [N-2:0] req_ext,
  input  logic         xfer_done,
  output logic         gnt_host,
  output logic [N-2:0] gnt_ext
);
  logic [N-1:0]         req_all;
  logic [N-1:0]         gnt_all;
  logic [N-1:0][IW-1:0] order;
  logic                 any_req;
  logic [IW-1:0]        pick;
  logic [IW-1:0]        owner;
  logic                 list_upd;

  assign req_all = {req_ext, req_host};

  mtl_prio_list #(.N(N), .IW(IW)) u_list (
    .clk(clk), .rst(rst), .upd(list_upd), .winner(owner), .order(order)
  );

  mtl_pick_winner #(.N(N), .IW(IW)) u_pick (
    .req(req_all), .mode_rr(mode_rr), .order(order),
    .any_req(any_req), .winner(pick)
  );

  mtl_grant_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .any_req(any_req), .pick(pick), .done(xfer_done),
    .mode_rr(mode_rr), .gnt(gnt_all), .owner(owner), .list_upd(list_upd)
  );

  assign gnt_host = gnt_all[0];
  assign gnt_ext  = gnt_all[N-1:1];
endmodule

// File: rtl/mtl_bus_arbiter_chk.sv
module mtl_bus_arbiter_chk #(
  parameter int N  = mtl_arb_pkg::NUM_MASTERS,
  parameter int IW = mtl_arb_pkg::IDX_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N-1:0]         req,
  input logic [N-1:0]         gnt,
  input logic                 done,
  input logic [N-1:0][IW-1:0] order
);
  logic [N-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < N; i++)
      if (int'(order[i]) < N) seen[order[i]] = 1'b1;
  end

  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  assert_grant_to_requester_R1: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && $past(gnt) == '0) |-> (($past(req) & gnt) != '0));
  assert_hold_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && !done) |=> (gnt == $past(gnt)));
  assert_release_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && done) |=> (gnt == '0));
  assert_list_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !(done && gnt != '0) |=> $stable(order));
  assert_list_permutation_R9: assert property (@(posedge clk) disable iff (rst)
    seen == '1);
endmodule

bind mtl_bus_arbiter mtl_bus_arbiter_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .req({req_ext, req_host}), .gnt({gnt_ext, gnt_host}),
  .done(xfer_done), .order(order)
);

// File: tb/mtl_bus_arbiter_test.sv
module mtl_bus_arbiter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_rr = 1'b0;
  logic       req_host = 1'b0;
  logic [3:0] req_ext = '0;
  logic       xfer_done = 1'b0;
  logic       gnt_host;
  logic [3:0] gnt_ext;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  mtl_bus_arbiter uut (
    .clk(clk), .rst(rst), .mode_rr(mode_rr), .req_host(req_host),
    .req_ext(req_ext), .xfer_done(xfer_done), .gnt_host(gnt_host), .gnt_ext(gnt_ext)
  );

  // Row: {mode, req[4:0] (bit0 = host), expected grant[4:0]}
  localparam int ROWS = 12;
  localparam logic [10:0] TABLE [ROWS] = '{
    {1'b1, 5'b00010, 5'b00010}, // R3 R5: list 0,2,3,4,1
    {1'b1, 5'b11111, 5'b00001}, // list 2,3,4,1,0
    {1'b1, 5'b01000, 5'b01000}, // list 2,4,1,0,3
    {1'b1, 5'b11011, 5'b10000}, // R4: 4 wins; list 2,1,0,3,4
    {1'b1, 5'b01011, 5'b00010}, // list 2,0,3,4,1
    {1'b0, 5'b11110, 5'b00010}, // R2 fixed
    {1'b0, 5'b11100, 5'b00100}, // R2 fixed, R6 list untouched
    {1'b1, 5'b11110, 5'b00100}, // R6: 2 wins only if fixed left list; list 0,3,4,1,2
    {1'b1, 5'b00000, 5'b00000}, // R8 no request
    {1'b1, 5'b10010, 5'b10000}, // list 0,3,1,2,4
    {1'b1, 5'b10110, 5'b00010}, // list 0,3,2,4,1
    {1'b1, 5'b10101, 5'b00001}  // list 3,2,4,1,0
  };

  function automatic logic [4:0] gnt_now();
    return {gnt_ext, gnt_host};
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grant actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_req(logic [4:0] r);
    req_host = r[0];
    req_ext  = r[4:1];
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset state", gnt_now(), 5'b00000);

    for (int i = 0; i < ROWS; i++) begin
      mode_rr = TABLE[i][10];
      set_req(TABLE[i][9:5]);
      @(negedge clk);
      check($sformatf("R1 R2 R4 R8 row %0d", i), gnt_now(), TABLE[i][4:0]);
      if (TABLE[i][4:0] != 5'b00000) begin
        xfer_done = 1'b1;
        set_req(5'b00000);
        @(negedge clk);
        xfer_done = 1'b0;
        check($sformatf("R7 release row %0d", i), gnt_now(), 5'b00000);
      end
    end
    // List now 3,2,4,1,0.

    // R7: hold while requests change and no completion.
    set_req(5'b00100);
    @(negedge clk);
    check("R7 grant 2", gnt_now(), 5'b00100);
    set_req(5'b01001);
    repeat (3) @(negedge clk);
    check("R7 hold despite new requests", gnt_now(), 5'b00100);
    // Complete with requests 0 and 3 still high: list 3,4,1,0,2.
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check("R7 zero after done", gnt_now(), 5'b00000);
    @(negedge clk);
    check("R7 R4 regrant next cycle", gnt_now(), 5'b01000);

    // R10: reset mid-transfer, list back to 0,1,2,3,4.
    rst = 1'b1;
    @(negedge clk);
    check("R10 grant cleared by reset", gnt_now(), 5'b00000);
    rst = 1'b0;
    set_req(5'b11111);
    @(negedge clk);
    check("R10 R3 list restored", gnt_now(), 5'b00001);
    xfer_done = 1'b1;
    set_req(5'b00000);
    @(negedge clk);
    xfer_done = 1'b0;
    // R5: list 1,2,3,4,0 -> 0 and 4 requesting, 4 now above 0.
    set_req(5'b10001);
    @(negedge clk);
    check("R5 host moved to tail", gnt_now(), 5'b10000);
    xfer_done = 1'b1;
    set_req(5'b00000);
    @(negedge clk);
    xfer_done = 1'b0;
    // R8: idle with no requests keeps grant zero.
    repeat (2) @(negedge clk);
    check("R8 idle no grant", gnt_now(), 5'b00000);
    finish_run();
  end
endmodule